// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer arithmetic and logic unit that sits next to an address generator in a signal-processing datapath. Each cycle in which an operation is presented, it takes two operands, an opcode and an unsigned-mode bit. It registers a result word and a four-bit status word holding zero, negative, overflow and carry. The operations cover addition, subtraction, right shifts, rotation in either direction, bitwise logic, absolute value, minimum, maximum and compare.

A separate condition evaluator reads the stored status word and answers one of six branch-style questions: equal, less than, less or equal, and their negations. Each question can be asked in signed or unsigned form. A sequencer uses this to decide branches on the outcome of an earlier compare or arithmetic operation. Compare changes only the status word and leaves the result register as it was.

Top module: `ialu_core`

## Requirements
- R1: ADD (opcode 0) returns opa+opb and sets C to the carry out. SUB (opcode 1) returns opa-opb and sets C to the borrow, meaning C=1 when opa is below opb as unsigned numbers. With unsigned_mode=0, V is two's-complement overflow; with unsigned_mode=1, V is a copy of C.
- R2: The arithmetic right shift (opcode 2) fills with the sign bit and the logical right shift (opcode 3) fills with zeros. Both shift opa by opb[4:0], and both clear V and C.
- R3: Rotate (opcode 4) treats opb[5:0] as a signed amount. A positive amount rotates opa left and a negative amount rotates it right, modulo 32. V and C are cleared.
- R4: AND (5), AND-NOT opa&~opb (6), NOT ~opa (7), OR (8) and XOR (9) produce bitwise results and clear V and C.
- R5: ABS (opcode 10) returns the magnitude of signed opa and clears C. It sets V only for the most negative value, which is returned unchanged.
- R6: MIN (11) and MAX (12) select an operand by signed comparison, or by unsigned comparison when unsigned_mode=1. Both clear V and C.
- R7: CMP (opcode 13) sets all four flags as SUB would and leaves result unchanged.
- R8: Every operation that writes the result sets Z when the result is zero and sets N to the result's top bit. flags is {Z,N,V,C} from bit 3 down to bit 0.
- R9: Opcodes 14 and 15, and any cycle with op_valid low, leave result and flags unchanged.
- R10: cond_true evaluates cond_sel against the stored flags. The codes are 0 EQ, 1 LT, 2 LE, 3 NEQ, 4 NLT and 5 NLE; codes 6 and 7 give 0. LT is N^V when cond_unsigned=0 and C when cond_unsigned=1, and LE is LT|Z.
- R11: Reset clears result and flags to zero.
- R12: result and flags take their new values at the clock edge that samples op_valid high, and not before. cond_true follows the stored flags and cond_sel with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Perform the presented operation at this edge |
| opcode | input | 4 | Operation code, see R1 to R9 |
| unsigned_mode | input | 1 | Unsigned interpretation for arithmetic and min/max |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand or shift/rotate amount |
| cond_sel | input | 3 | Condition to evaluate |
| cond_unsigned | input | 1 | Evaluate LT/LE family on the carry flag |
| result | output | 32 | Registered result |
| flags | output | 4 | Registered {Z,N,V,C} |
| cond_true | output | 1 | Condition answer from the stored flags |

## Verification
An operation drives its result and flags one clock edge after it is presented. The bench therefore drives each operation on a falling edge and samples on the following falling edge, after exactly one rising edge has registered it. For R12 it also samples once just before that rising edge, to show that the old value is still held. cond_true has no register in its path, so condition checks set cond_sel and sample a nanosecond later, in the same low phase, against flags left by a preceding compare.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_ASR  = 4'd2,
      OP_LSR  = 4'd3,
      OP_ROT  = 4'd4,
      OP_AND  = 4'd5,
      OP_ANDN = 4'd6,
      OP_NOT  = 4'd7,
      OP_OR   = 4'd8,
      OP_XOR  = 4'd9,
      OP_ABS  = 4'd10,
      OP_MIN  = 4'd11,
      OP_MAX  = 4'd12,
      OP_CMP  = 4'd13
   } op_e;

   typedef enum logic [2:0] {
      CC_EQ  = 3'd0,
      CC_LT  = 3'd1,
      CC_LE  = 3'd2,
      CC_NEQ = 3'd3,
      CC_NLT = 3'd4,
      CC_NLE = 3'd5
   } cond_e;

   typedef enum logic [1:0] {
      SH_LSR = 2'd0,
      SH_ASR = 2'd1,
      SH_ROL = 2'd2
   } sh_mode_e;

   typedef struct packed {
      logic z;
      logic n;
      logic v;
      logic c;
   } flags_t;

endpackage

// File: rtl/ialu_addsub.sv
module ialu_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   input  logic             uns,
   output logic [WIDTH-1:0] sum,
   output logic             c_flag,
   output logic             v_flag
);
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   full;
   logic             s_ovf;

   assign b_eff  = sub ? ~b : b;
   assign full   = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
   assign sum    = full[WIDTH-1:0];
   // carry for add, borrow for subtract
   assign c_flag = sub ? ~full[WIDTH] : full[WIDTH];
   assign s_ovf  = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
   assign v_flag = uns ? c_flag : s_ovf;
endmodule

// File: rtl/ialu_shift.sv
module ialu_shift
   import ialu_pkg::*;
#(
   parameter int WIDTH = 32,
   localparam int SHW = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] val,
   input  logic [SHW-1:0]   amt,
   input  sh_mode_e         mode,
   output logic [WIDTH-1:0] res
);
   logic [WIDTH-1:0] stg [SHW+1];
   logic             fill;

   assign fill   = (mode == SH_ASR) ? val[WIDTH-1] : 1'b0;
   assign stg[0] = val;

   for (genvar i = 0; i < SHW; i++) begin : g_stage
      localparam int D = 1 << i;
      logic [WIDTH-1:0] moved;
      always_comb begin
         if (mode == SH_ROL) moved = {stg[i][WIDTH-1-D:0], stg[i][WIDTH-1:WIDTH-D]};
         else                moved = {{D{fill}}, stg[i][WIDTH-1:D]};
      end
      assign stg[i+1] = amt[i] ? moved : stg[i];
   end

   assign res = stg[SHW];
endmodule

// File: rtl/ialu_cond.sv
module ialu_cond
   import ialu_pkg::*;
(
   input  flags_t     fl,
   input  logic [2:0] sel,
   input  logic       uns,
   output logic       hit
);
   logic lt;
   logic le;

   assign lt = uns ? fl.c : (fl.n ^ fl.v);
   assign le = lt | fl.z;

   always_comb begin
      case (cond_e'(sel))
         CC_EQ:   hit = fl.z;
         CC_LT:   hit = lt;
         CC_LE:   hit = le;
         CC_NEQ:  hit = ~fl.z;
         CC_NLT:  hit = ~lt;
         CC_NLE:  hit = ~le;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/ialu_core.sv
module ialu_core
   import ialu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [3:0]       opcode,
   input  logic             unsigned_mode,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [2:0]       cond_sel,
   input  logic             cond_unsigned,
   output logic [WIDTH-1:0] result,
   output logic [3:0]       flags,
   output logic             cond_true
);
   localparam int SHW = $clog2(WIDTH);
   localparam logic [WIDTH-1:0] MINV = {1'b1, {(WIDTH-1){1'b0}}};

   if (WIDTH < 8 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("ialu_core: WIDTH must be a power of two of at least 8");
   end

   op_e              op;
   logic             do_sub;
   logic [WIDTH-1:0] as_sum;
   logic             as_c;
   logic             as_v;
   sh_mode_e         sh_mode;
   logic [WIDTH-1:0] sh_res;
   logic             a_lt_b;
   logic [WIDTH-1:0] nres;
   logic [WIDTH-1:0] zn_src;
   logic             nv;
   logic             nc;
   logic             wr_res;
   logic             wr_fl;
   flags_t           flag_q;
   flags_t           nfl;

   assign op     = op_e'(opcode);
   assign do_sub = (op == OP_SUB) || (op == OP_CMP);
   assign a_lt_b = unsigned_mode ? (opa < opb) : ($signed(opa) < $signed(opb));

   always_comb begin
      case (op)
         OP_ASR:  sh_mode = SH_ASR;
         OP_ROT:  sh_mode = SH_ROL;
         default: sh_mode = SH_LSR;
      endcase
   end

   ialu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a      (opa),
      .b      (opb),
      .sub    (do_sub),
      .uns    (unsigned_mode),
      .sum    (as_sum),
      .c_flag (as_c),
      .v_flag (as_v)
   );

   // a signed rotate amount reduces to a left rotate by its low bits
   ialu_shift #(.WIDTH(WIDTH)) u_shift (
      .val  (opa),
      .amt  (opb[SHW-1:0]),
      .mode (sh_mode),
      .res  (sh_res)
   );

   always_comb begin
      nres   = result;
      nv     = 1'b0;
      nc     = 1'b0;
      wr_res = 1'b1;
      wr_fl  = 1'b1;
      case (op)
         OP_ADD, OP_SUB: begin nres = as_sum; nv = as_v; nc = as_c; end
         OP_CMP:         begin nv = as_v; nc = as_c; wr_res = 1'b0; end
         OP_ASR, OP_LSR, OP_ROT: nres = sh_res;
         OP_AND:  nres = opa & opb;
         OP_ANDN: nres = opa & ~opb;
         OP_NOT:  nres = ~opa;
         OP_OR:   nres = opa | opb;
         OP_XOR:  nres = opa ^ opb;
         OP_ABS:  begin
            nres = opa[WIDTH-1] ? ('0 - opa) : opa;
            nv   = (opa == MINV);
         end
         OP_MIN:  nres = a_lt_b ? opa : opb;
         OP_MAX:  nres = a_lt_b ? opb : opa;
         default: begin wr_res = 1'b0; wr_fl = 1'b0; end
      endcase
      zn_src = (op == OP_CMP) ? as_sum : nres;
      nfl.z  = (zn_src == '0);
      nfl.n  = zn_src[WIDTH-1];
      nfl.v  = nv;
      nfl.c  = nc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
         flag_q <= '0;
      end else if (op_valid) begin
         if (wr_res) result <= nres;
         if (wr_fl)  flag_q <= nfl;
      end
   end

   assign flags = flag_q;

   ialu_cond u_cond (
      .fl  (flag_q),
      .sel (cond_sel),
      .uns (cond_unsigned),
      .hit (cond_true)
   );

   // R9
   reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (opcode >= 4'd14) |=> $stable(result) && $stable(flags));
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(result) && $stable(flags));
   // R7
   cmp_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (opcode == 4'd13) |=> $stable(result));
   // R4
   logic_clears_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (opcode >= 4'd5) && (opcode <= 4'd9) |=> (flags[1:0] == 2'b00));
   // R8
   zn_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (opcode <= 4'd12) |=> (flags[3] == (result == '0)) && (flags[2] == result[WIDTH-1]));
   // R5
   abs_most_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (opcode == 4'd10) && (opa == MINV) |=> (result == MINV) && flags[1]);
endmodule

// File: tb/ialu_core_bench.sv
`timescale 1ns/1ps
module ialu_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  opcode = '0;
   logic        unsigned_mode = 1'b0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic [2:0]  cond_sel = '0;
   logic        cond_unsigned = 1'b0;
   logic [31:0] result;
   logic [3:0]  flags;
   logic        cond_true;
   int          checks = 0;
   int          errors = 0;

   always #2 clk = ~clk;

   ialu_core u_ialu_core (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
      .unsigned_mode(unsigned_mode), .opa(opa), .opb(opb), .cond_sel(cond_sel),
      .cond_unsigned(cond_unsigned), .result(result), .flags(flags), .cond_true(cond_true)
   );

   // {uns, op, a, b, expected result, expected flags ZNVC}
   localparam int NV = 24;
   localparam logic [104:0] VEC [NV] = '{
      {1'b0, 4'd0,  32'h00000007, 32'h00000005, 32'h0000000C, 4'b0000},
      {1'b0, 4'd0,  32'h7FFFFFFF, 32'h00000001, 32'h80000000, 4'b0110},
      {1'b1, 4'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'b1011},
      {1'b0, 4'd1,  32'h00000005, 32'h00000007, 32'hFFFFFFFE, 4'b0101},
      {1'b0, 4'd1,  32'h80000000, 32'h00000001, 32'h7FFFFFFF, 4'b0010},
      {1'b0, 4'd2,  32'h80000010, 32'h00000004, 32'hF8000001, 4'b0100},
      {1'b0, 4'd3,  32'h80000010, 32'h00000004, 32'h08000001, 4'b0000},
      {1'b0, 4'd4,  32'h80000001, 32'h00000001, 32'h00000003, 4'b0000},
      {1'b0, 4'd4,  32'h00000003, 32'h0000003F, 32'h80000001, 4'b0100},
      {1'b0, 4'd4,  32'h12345678, 32'h00000038, 32'h78123456, 4'b0000},
      {1'b0, 4'd5,  32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 4'b0100},
      {1'b0, 4'd6,  32'hF0F0F0F0, 32'hFF00FF00, 32'h00F000F0, 4'b0000},
      {1'b0, 4'd7,  32'hFFFFFFFF, 32'h00000000, 32'h00000000, 4'b1000},
      {1'b0, 4'd8,  32'h0F0F0000, 32'h000000F0, 32'h0F0F00F0, 4'b0000},
      {1'b0, 4'd9,  32'hA5A5A5A5, 32'hA5A5A5A5, 32'h00000000, 4'b1000},
      {1'b0, 4'd10, 32'hFFFFFFF6, 32'h00000000, 32'h0000000A, 4'b0000},
      {1'b0, 4'd10, 32'h80000000, 32'h00000000, 32'h80000000, 4'b0110},
      {1'b0, 4'd11, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 4'b0100},
      {1'b1, 4'd11, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 4'b0000},
      {1'b0, 4'd12, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 4'b0000},
      {1'b1, 4'd12, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 4'b0100},
      {1'b0, 4'd13, 32'h00000003, 32'h00000003, 32'hFFFFFFFF, 4'b1000},
      {1'b0, 4'd13, 32'h00000001, 32'h00000002, 32'hFFFFFFFF, 4'b0101},
      {1'b0, 4'd14, 32'h12345678, 32'h00000001, 32'hFFFFFFFF, 4'b0101}
   };

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'd0, 4'd1: return "R1";
         4'd2, 4'd3: return "R2";
         4'd4:       return "R3";
         4'd10:      return "R5";
         4'd11, 4'd12: return "R6";
         4'd13:      return "R7";
         4'd14, 4'd15: return "R9";
         default:    return "R4";
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic uns, input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      op_valid = 1'b1; unsigned_mode = uns; opcode = op; opa = a; opb = b;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic cond_chk(input string req, input logic [2:0] sel, input logic uns, input logic exp);
      cond_sel = sel; cond_unsigned = uns;
      #1;
      chk(req, {31'b0, cond_true}, {31'b0, exp});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R11 reset state
      repeat (3) @(negedge clk);
      chk("R11", result, 32'h0);
      chk("R11", {28'b0, flags}, 32'h0);
      cond_chk("R11", 3'd0, 1'b0, 1'b0);
      cond_chk("R11", 3'd3, 1'b0, 1'b1);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         do_op(VEC[i][104], VEC[i][103:100], VEC[i][99:68], VEC[i][67:36]);
         chk(req_of(VEC[i][103:100]), result, VEC[i][35:4]);
         chk(req_of(VEC[i][103:100]), {28'b0, flags}, {28'b0, VEC[i][3:0]});
      end

      // R10: -1 vs 1, signed less, unsigned greater (flags 0100)
      do_op(1'b0, 4'd13, 32'hFFFFFFFF, 32'h00000001);
      chk("R7", {28'b0, flags}, 32'h4);
      cond_chk("R10", 3'd1, 1'b0, 1'b1);
      cond_chk("R10", 3'd1, 1'b1, 1'b0);
      cond_chk("R10", 3'd2, 1'b0, 1'b1);
      cond_chk("R10", 3'd4, 1'b0, 1'b0);
      cond_chk("R10", 3'd5, 1'b1, 1'b1);
      cond_chk("R10", 3'd0, 1'b0, 1'b0);
      cond_chk("R10", 3'd3, 1'b0, 1'b1);
      cond_chk("R10", 3'd6, 1'b0, 1'b0);
      // R10: overflowing signed compare still orders correctly (flags 0010)
      do_op(1'b0, 4'd13, 32'h80000000, 32'h00000001);
      chk("R7", {28'b0, flags}, 32'h2);
      cond_chk("R10", 3'd1, 1'b0, 1'b1);
      cond_chk("R10", 3'd1, 1'b1, 1'b0);
      // R10: equal operands (flags 1000)
      do_op(1'b0, 4'd13, 32'h00000003, 32'h00000003);
      cond_chk("R10", 3'd0, 1'b0, 1'b1);
      cond_chk("R10", 3'd2, 1'b1, 1'b1);
      cond_chk("R10", 3'd1, 1'b0, 1'b0);
      cond_chk("R10", 3'd5, 1'b0, 1'b0);
      cond_chk("R10", 3'd4, 1'b1, 1'b1);
      cond_chk("R10", 3'd7, 1'b1, 1'b0);

      // R9: op_valid low leaves state alone
      @(negedge clk);
      op_valid = 1'b0; opcode = 4'd0; opa = 32'h1; opb = 32'h1;
      @(negedge clk);
      @(negedge clk);
      chk("R9", result, 32'hFFFFFFFF);
      chk("R9", {28'b0, flags}, 32'h8);

      // R12: new value only after the sampling edge
      @(negedge clk);
      op_valid = 1'b1; unsigned_mode = 1'b0; opcode = 4'd0; opa = 32'h1; opb = 32'h1;
      #1;
      chk("R12", result, 32'hFFFFFFFF);
      @(negedge clk);
      op_valid = 1'b0;
      chk("R12", result, 32'h2);

      // R11: reset mid-run
      rst_n = 1'b0;
      #1;
      chk("R11", result, 32'h0);
      chk("R11", {28'b0, flags}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule